// File: doc/BRIEF.md
# Iterative Triple-DES Block Engine

This block encrypts or decrypts one 64-bit block with triple DES under three independent 56-bit keys. A single Feistel round datapath is reused for every round of every pass. Encryption runs the three DES passes in the order encrypt with the first key, decrypt with the second key, then encrypt with the third key. Decryption runs them in the reverse order: decrypt with the third key, encrypt with the second key, then decrypt with the first key. One round is computed per clock, so a whole operation takes 48 clock cycles.

To start an operation, the user presents the block, the keys and the direction, then pulses `start` for one cycle. The first round is computed on the same edge that accepts the request. The second key and the key of the last pass are captured at that edge, so the inputs may change afterwards. When the result is ready, it appears on `dout` together with a one-cycle `done` pulse. It stays on `dout` until the next operation completes. Inside a pass, the subkeys are produced on the fly. Encryption rotates the key halves left and decryption rotates them right, so no subkey storage is needed.

Top module: `des3_engine`

## Requirements
- R1: While reset is held and after it is released, `done` is 0 and `dout` is all zeros until the first operation completes.
- R2: Each 56-bit key input carries a 64-bit DES key with the least significant (parity) bit of every byte removed, bytes kept in order with the first byte in bits 55:49. With all three keys equal, encryption produces the single-DES ciphertext of `din`.
- R3: Encryption (`decrypt` = 0) computes E(key3, D(key2, E(key1, din))).
- R4: Decryption (`decrypt` = 1) computes D(key1, E(key2, D(key3, din))).
- R5: Decrypting the result of an encryption under the same three distinct keys returns the original block.
- R6: `done` rises on the 48th rising edge, counting as the first the edge that samples `start` high while the engine is idle.
- R7: `done` is high for exactly one cycle per operation.
- R8: `dout` changes only on the edge that raises `done`, and holds its value otherwise.
- R9: A `start` pulse while an operation runs is ignored: the running result, its timing and its keys are unaffected, and no extra operation follows.
- R10: A new `start` presented in the cycle where `done` is high is accepted, and that operation completes 48 cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, honoured only while idle |
| decrypt | input | 1 | 1 selects the decryption order, 0 the encryption order |
| din | input | 64 | Input block, sampled with an accepted start |
| key1 | input | 56 | First key, parity bits removed |
| key2 | input | 56 | Second key, parity bits removed |
| key3 | input | 56 | Third key, parity bits removed |
| dout | output | 64 | Result block, held until the next completion |
| done | output | 1 | One-cycle pulse marking a new result on dout |

## Verification
The assertions assume that `start` is a synchronous level that the bench changes only away from the rising edge. They also assume that `din`, `decrypt` and the three keys are steady at the edge where an idle engine accepts `start`. The bench drives every input on the falling edge, so each accepted request sees settled operands. When it tests that a request is ignored, it changes `din`, the keys and the direction in mid-operation. This shows that only values captured at acceptance reach the result. Reset is asserted from time zero, so the latency counter in the checker starts from a known state.

// File: rtl/des3_pkg.sv
package des3_pkg;

   localparam int unsigned IP_TAB [64] = '{
      58,50,42,34,26,18,10,2, 60,52,44,36,28,20,12,4,
      62,54,46,38,30,22,14,6, 64,56,48,40,32,24,16,8,
      57,49,41,33,25,17,9,1,  59,51,43,35,27,19,11,3,
      61,53,45,37,29,21,13,5, 63,55,47,39,31,23,15,7};

   localparam int unsigned P_TAB [32] = '{
      16,7,20,21,29,12,28,17, 1,15,23,26,5,18,31,10,
      2,8,24,14,32,27,3,9,    19,13,30,6,22,11,4,25};

   localparam int unsigned PC1_TAB [56] = '{
      57,49,41,33,25,17,9,  1,58,50,42,34,26,18,
      10,2,59,51,43,35,27,  19,11,3,60,52,44,36,
      63,55,47,39,31,23,15, 7,62,54,46,38,30,22,
      14,6,61,53,45,37,29,  21,13,5,28,20,12,4};

   localparam int unsigned PC2_TAB [48] = '{
      14,17,11,24,1,5,   3,28,15,6,21,10,
      23,19,12,4,26,8,   16,7,27,20,13,2,
      41,52,31,37,47,55, 30,40,51,45,33,48,
      44,49,39,56,34,53, 46,42,50,36,29,32};

   localparam int unsigned SB0 [64] = '{
      14,4,13,1,2,15,11,8,3,10,6,12,5,9,0,7,
      0,15,7,4,14,2,13,1,10,6,12,11,9,5,3,8,
      4,1,14,8,13,6,2,11,15,12,9,7,3,10,5,0,
      15,12,8,2,4,9,1,7,5,11,3,14,10,0,6,13};
   localparam int unsigned SB1 [64] = '{
      15,1,8,14,6,11,3,4,9,7,2,13,12,0,5,10,
      3,13,4,7,15,2,8,14,12,0,1,10,6,9,11,5,
      0,14,7,11,10,4,13,1,5,8,12,6,9,3,2,15,
      13,8,10,1,3,15,4,2,11,6,7,12,0,5,14,9};
   localparam int unsigned SB2 [64] = '{
      10,0,9,14,6,3,15,5,1,13,12,7,11,4,2,8,
      13,7,0,9,3,4,6,10,2,8,5,14,12,11,15,1,
      13,6,4,9,8,15,3,0,11,1,2,12,5,10,14,7,
      1,10,13,0,6,9,8,7,4,15,14,3,11,5,2,12};
   localparam int unsigned SB3 [64] = '{
      7,13,14,3,0,6,9,10,1,2,8,5,11,12,4,15,
      13,8,11,5,6,15,0,3,4,7,2,12,1,10,14,9,
      10,6,9,0,12,11,7,13,15,1,3,14,5,2,8,4,
      3,15,0,6,10,1,13,8,9,4,5,11,12,7,2,14};
   localparam int unsigned SB4 [64] = '{
      2,12,4,1,7,10,11,6,8,5,3,15,13,0,14,9,
      14,11,2,12,4,7,13,1,5,0,15,10,3,9,8,6,
      4,2,1,11,10,13,7,8,15,9,12,5,6,3,0,14,
      11,8,12,7,1,14,2,13,6,15,0,9,10,4,5,3};
   localparam int unsigned SB5 [64] = '{
      12,1,10,15,9,2,6,8,0,13,3,4,14,7,5,11,
      10,15,4,2,7,12,9,5,6,1,13,14,0,11,3,8,
      9,14,15,5,2,8,12,3,7,0,4,10,1,13,11,6,
      4,3,2,12,9,5,15,10,11,14,1,7,6,0,8,13};
   localparam int unsigned SB6 [64] = '{
      4,11,2,14,15,0,8,13,3,12,9,7,5,10,6,1,
      13,0,11,7,4,9,1,10,14,3,5,12,2,15,8,6,
      1,4,11,13,12,3,7,14,10,15,6,8,0,5,9,2,
      6,11,13,8,1,4,10,7,9,5,0,15,14,2,3,12};
   localparam int unsigned SB7 [64] = '{
      13,2,8,4,6,15,11,1,10,9,3,14,5,0,12,7,
      1,15,13,8,10,3,7,4,12,5,6,11,0,14,9,2,
      7,11,4,1,9,12,14,2,0,6,10,13,15,3,5,8,
      2,1,14,7,4,10,8,13,15,12,9,0,3,5,6,11};

   // Tables number bits from 1 at the most significant end.
   function automatic logic [63:0] ip_perm(input logic [63:0] x);
      logic [63:0] y;
      for (int i = 0; i < 64; i++) y[63-i] = x[64-IP_TAB[i]];
      return y;
   endfunction

   // Inverse of ip_perm, derived from the same table.
   function automatic logic [63:0] fp_perm(input logic [63:0] x);
      logic [63:0] y;
      for (int i = 0; i < 64; i++) y[64-IP_TAB[i]] = x[63-i];
      return y;
   endfunction

   // Expansion: group g takes bits 4g .. 4g+5 of a ring (1-based, wrapping).
   function automatic logic [47:0] expand_r(input logic [31:0] r);
      logic [47:0] y;
      for (int g = 0; g < 8; g++)
         for (int k = 0; k < 6; k++)
            y[47-(6*g+k)] = r[31-((4*g+k+31)%32)];
      return y;
   endfunction

   function automatic logic [31:0] p_perm(input logic [31:0] x);
      logic [31:0] y;
      for (int i = 0; i < 32; i++) y[31-i] = x[32-P_TAB[i]];
      return y;
   endfunction

   // Re-inserts the dropped parity positions, then applies PC-1.
   function automatic logic [55:0] pc1_key(input logic [55:0] k);
      logic [63:0] full;
      logic [55:0] y;
      for (int b = 0; b < 8; b++) begin
         full[63-8*b -: 7] = k[55-7*b -: 7];
         full[56-8*b]      = 1'b0;
      end
      for (int i = 0; i < 56; i++) y[55-i] = full[64-PC1_TAB[i]];
      return y;
   endfunction

   function automatic logic [47:0] pc2_key(input logic [55:0] cd);
      logic [47:0] y;
      for (int i = 0; i < 48; i++) y[47-i] = cd[56-PC2_TAB[i]];
      return y;
   endfunction

   function automatic logic [3:0] sbox(input int unsigned n, input logic [5:0] b);
      int unsigned idx;
      int unsigned v;
      idx = 32'({b[5], b[0], b[4:1]});
      case (n)
         0: v = SB0[idx];
         1: v = SB1[idx];
         2: v = SB2[idx];
         3: v = SB3[idx];
         4: v = SB4[idx];
         5: v = SB5[idx];
         6: v = SB6[idx];
         default: v = SB7[idx];
      endcase
      return v[3:0];
   endfunction

endpackage

// File: rtl/des3_round_f.sv
module des3_round_f
   import des3_pkg::*;
(
   input  logic [31:0] r_in,
   input  logic [47:0] subkey,
   output logic [31:0] f_out
);
   localparam int LANES = 8;

   logic [47:0] mixed;
   logic [31:0] sb_out;

   assign mixed = expand_r(r_in) ^ subkey;

   for (genvar s = 0; s < LANES; s++) begin : g_lane
      assign sb_out[31-4*s -: 4] = sbox(s, mixed[47-6*s -: 6]);
   end

   assign f_out = p_perm(sb_out);
endmodule

// File: rtl/des3_subkey.sv
module des3_subkey
   import des3_pkg::*;
#(
   parameter int ROUNDS = 16,
   localparam int RND_W = $clog2(ROUNDS)
) (
   input  logic [55:0]      cd_base,
   input  logic             dec,
   input  logic [RND_W-1:0] rnd,
   output logic [47:0]      subkey,
   output logic [55:0]      cd_next
);
   localparam int HALF = 28;

   function automatic logic single_step(input logic [RND_W-1:0] r);
      return (r == RND_W'(0)) || (r == RND_W'(1)) ||
             (r == RND_W'(8)) || (r == RND_W'(ROUNDS-1));
   endfunction

   logic        one_enc, one_dec;
   logic [55:0] rot_l, rot_r, cd_use;

   assign one_enc = single_step(rnd);
   assign one_dec = single_step(RND_W'(ROUNDS-1) - rnd);

   for (genvar h = 0; h < 2; h++) begin : g_half
      logic [HALF-1:0] c;
      assign c = cd_base[HALF*(2-h)-1 -: HALF];
      assign rot_l[HALF*(2-h)-1 -: HALF] = one_enc ? {c[HALF-2:0], c[HALF-1]}
                                                   : {c[HALF-3:0], c[HALF-1:HALF-2]};
      assign rot_r[HALF*(2-h)-1 -: HALF] = one_dec ? {c[0], c[HALF-1:1]}
                                                   : {c[1:0], c[HALF-1:2]};
   end

   // Encrypt: rotate left, then use. Decrypt: use, then rotate right.
   assign cd_use  = dec ? cd_base : rot_l;
   assign cd_next = dec ? rot_r   : rot_l;
   assign subkey  = pc2_key(cd_use);
endmodule

// File: rtl/des3_seq.sv
module des3_seq #(
   parameter int OP_CYC = 48,
   localparam int CNT_W = $clog2(OP_CYC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic             busy,
   output logic             active,
   output logic [CNT_W-1:0] cnt,
   output logic             done
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(OP_CYC-1);

   assign active = busy | start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
         done <= 1'b0;
      end else begin
         done <= busy && (cnt == LAST);
         if (!busy) begin
            if (start) begin
               busy <= 1'b1;
               cnt  <= CNT_W'(1);
            end
         end else if (cnt == LAST) begin
            busy <= 1'b0;
            cnt  <= '0;
         end else begin
            cnt <= cnt + CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/des3_engine.sv
module des3_engine
   import des3_pkg::*;
#(
   parameter int BLK_W  = 64,
   parameter int KEY_W  = 56,
   parameter int ROUNDS = 16,
   parameter int PASSES = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             decrypt,
   input  logic [BLK_W-1:0] din,
   input  logic [KEY_W-1:0] key1,
   input  logic [KEY_W-1:0] key2,
   input  logic [KEY_W-1:0] key3,
   output logic [BLK_W-1:0] dout,
   output logic             done
);
   localparam int OP_CYC = ROUNDS * PASSES;
   localparam int CNT_W  = $clog2(OP_CYC);
   localparam int RND_W  = $clog2(ROUNDS);
   localparam int PASS_W = CNT_W - RND_W;
   localparam int HW     = BLK_W / 2;

   if (BLK_W != 64) begin : g_bad_blk
      $error("des3_engine: BLK_W must be 64");
   end
   if (KEY_W != 56) begin : g_bad_key
      $error("des3_engine: KEY_W must be 56");
   end
   if (ROUNDS != 16) begin : g_bad_rnd
      $error("des3_engine: ROUNDS must be 16");
   end
   if (PASSES != 3) begin : g_bad_pass
      $error("des3_engine: PASSES must be 3");
   end

   logic              busy, active;
   logic [CNT_W-1:0]  cnt;
   logic [PASS_W-1:0] pass;
   logic [RND_W-1:0]  rnd;

   des3_seq #(.OP_CYC(OP_CYC)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .busy  (busy),
      .active(active),
      .cnt   (cnt),
      .done  (done)
   );

   assign pass = cnt[CNT_W-1:RND_W];
   assign rnd  = cnt[RND_W-1:0];

   logic [HW-1:0]    l_q, r_q, l_in, r_in, f_val, l_mix;
   logic [55:0]      cd_q, cd_base, cd_next;
   logic [KEY_W-1:0] k2_q, kfin_q;
   logic             mode_q, mode, dec_pass;
   logic [47:0]      subkey;
   logic             pass_end, op_end;

   assign {l_in, r_in} = busy ? {l_q, r_q} : ip_perm(din);
   assign cd_base      = busy ? cd_q : pc1_key(decrypt ? key3 : key1);
   assign mode         = busy ? mode_q : decrypt;
   // Middle pass runs opposite to the requested direction.
   assign dec_pass     = mode ^ (pass == PASS_W'(1));
   assign pass_end     = (rnd == RND_W'(ROUNDS-1));
   assign op_end       = pass_end && (pass == PASS_W'(PASSES-1));

   des3_subkey #(.ROUNDS(ROUNDS)) u_key (
      .cd_base(cd_base),
      .dec    (dec_pass),
      .rnd    (rnd),
      .subkey (subkey),
      .cd_next(cd_next)
   );

   des3_round_f u_f (
      .r_in  (r_in),
      .subkey(subkey),
      .f_out (f_val)
   );

   assign l_mix = l_in ^ f_val;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         l_q    <= '0;
         r_q    <= '0;
         cd_q   <= '0;
         k2_q   <= '0;
         kfin_q <= '0;
         mode_q <= 1'b0;
         dout   <= '0;
      end else begin
         if (start && !busy) begin
            k2_q   <= key2;
            kfin_q <= decrypt ? key1 : key3;
            mode_q <= decrypt;
         end
         if (active) begin
            if (pass_end) begin
               // Final permutation followed by the next initial one cancels;
               // only the closing half-swap remains.
               l_q  <= l_mix;
               r_q  <= r_in;
               cd_q <= pc1_key((pass == PASS_W'(0)) ? k2_q : kfin_q);
               if (op_end) dout <= fp_perm({l_mix, r_in});
            end else begin
               l_q  <= r_in;
               r_q  <= l_mix;
               cd_q <= cd_next;
            end
         end
      end
   end
endmodule

// File: rtl/des3_engine_chk.sv
module des3_engine_chk #(
   parameter int ROUNDS = 16,
   parameter int PASSES = 3
) (
   input logic        clk,
   input logic        rst_n,
   input logic        start,
   input logic        busy,
   input logic        done,
   input logic [63:0] dout
);
   localparam int OP_CYC = ROUNDS * PASSES;
   localparam int CW     = $clog2(OP_CYC + 1) + 1;

   logic [CW-1:0] since;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) since <= '0;
      else if (start && !busy) since <= CW'(1);
      else if (since == CW'(OP_CYC)) since <= '0;
      else if (since != '0) since <= since + CW'(1);
   end

   // R1
   reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> (!done && dout == '0));

   // R6
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (since == CW'(OP_CYC)));

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(dout));

   // R9
   no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && busy && since != CW'(OP_CYC)) |=> (since == $past(since) + CW'(1)));
endmodule

bind des3_engine des3_engine_chk #(.ROUNDS(ROUNDS), .PASSES(PASSES)) u_chk (
   .clk  (clk),
   .rst_n(rst_n),
   .start(start),
   .busy (busy),
   .done (done),
   .dout (dout)
);

// File: tb/des3_engine_test.sv
`timescale 1ns/1ps
module des3_engine_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        decrypt = 1'b0;
   logic [63:0] din = '0;
   logic [55:0] key1 = '0, key2 = '0, key3 = '0;
   logic [63:0] dout;
   logic        done;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   des3_engine uut (
      .clk(clk), .rst_n(rst_n), .start(start), .decrypt(decrypt),
      .din(din), .key1(key1), .key2(key2), .key3(key3),
      .dout(dout), .done(done)
   );

   localparam logic [63:0] KA  = 64'h133457799BBCDFF1;
   localparam logic [63:0] PA  = 64'h0123456789ABCDEF;
   localparam logic [63:0] CA  = 64'h85E813540F0AB405;
   localparam logic [63:0] KB  = 64'h0E329232EA6D0D73;
   localparam logic [63:0] PB  = 64'h8787878787878787;
   localparam logic [63:0] CB  = 64'h0000000000000000;
   localparam logic [63:0] KC  = 64'h0123456789ABCDEF;
   localparam logic [63:0] PC  = 64'h4E6F772069732074;
   localparam logic [63:0] CC  = 64'h3FA40E8A984D4815;
   localparam logic [63:0] KX  = 64'hFEDCBA9876543210;
   localparam logic [63:0] KY  = 64'h23456789ABCDEF01;
   localparam logic [63:0] KZ  = 64'h456789ABCDEF0123;

   // R2 key format: drop the low bit of each byte.
   function automatic logic [55:0] k56(input logic [63:0] k);
      logic [55:0] y;
      for (int b = 0; b < 8; b++) y[55-7*b -: 7] = k[63-8*b -: 7];
      return y;
   endfunction

   task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic check_int(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Issues one request at a falling edge; returns the result, the latency
   // in cycles and whether done stayed high one cycle too long.
   task automatic run_op(input bit dec, input logic [63:0] blk,
                         input logic [63:0] a, input logic [63:0] b, input logic [63:0] c,
                         output logic [63:0] res, output int lat, output bit long_done);
      decrypt = dec; din = blk; key1 = k56(a); key2 = k56(b); key3 = k56(c);
      start = 1'b1;
      lat = -1; res = 'x; long_done = 1'b0;
      for (int k = 1; k <= 80; k++) begin
         @(negedge clk);
         if (k == 1) start = 1'b0;
         if (done) begin
            lat = k;
            res = dout;
            break;
         end
      end
      @(negedge clk);
      long_done = done;
   endtask

   task automatic t_reset;
      check_int("R1 done after reset", int'(done), 0);
      check64("R1 dout after reset", dout, 64'h0);
   endtask

   task automatic t_single_des;
      logic [63:0] r; int lat; bit ld;
      run_op(1'b0, PA, KA, KA, KA, r, lat, ld);
      check64("R2 vector A", r, CA);
      check_int("R6 latency", lat, 48);
      check_int("R7 done width", int'(ld), 0);
      run_op(1'b0, PB, KB, KB, KB, r, lat, ld);
      check64("R2 vector B", r, CB);
      run_op(1'b0, PC, KC, KC, KC, r, lat, ld);
      check64("R2 vector C", r, CC);
      check_int("R6 latency C", lat, 48);
   endtask

   task automatic t_enc_order;
      logic [63:0] r; int lat; bit ld;
      // E(X) D(X) E(A) reduces to E(A)
      run_op(1'b0, PA, KX, KX, KA, r, lat, ld);
      check64("R3 third key dominates", r, CA);
      // E(A) D(Y) E(Y) reduces to E(A)
      run_op(1'b0, PA, KA, KY, KY, r, lat, ld);
      check64("R3 first key dominates", r, CA);
   endtask

   task automatic t_dec_order;
      logic [63:0] r; int lat; bit ld;
      // D(A) E(Y) D(Y) reduces to D(A) with A as key1
      run_op(1'b1, CA, KA, KY, KY, r, lat, ld);
      check64("R4 key1 last", r, PA);
      // D(X) E(X) D(A) reduces to D(A) with A as key3
      run_op(1'b1, CA, KX, KX, KA, r, lat, ld);
      check64("R4 key3 first", r, PA);
      check_int("R6 decrypt latency", lat, 48);
   endtask

   task automatic t_round_trip;
      logic [63:0] c, p; int lat; bit ld;
      run_op(1'b0, 64'h5468652071756663, KC, KY, KZ, c, lat, ld);
      checks++;
      if (c === 64'h5468652071756663) begin
         errors++;
         $display("FAIL R5 ciphertext: actual %h expected not %h", c, 64'h5468652071756663);
      end
      run_op(1'b1, c, KC, KY, KZ, p, lat, ld);
      check64("R5 round trip 1", p, 64'h5468652071756663);
      run_op(1'b0, 64'hFFFFFFFF00000000, KZ, KA, KB, c, lat, ld);
      run_op(1'b1, c, KZ, KA, KB, p, lat, ld);
      check64("R5 round trip 2", p, 64'hFFFFFFFF00000000);
   endtask

   task automatic t_ignore_start;
      int lat; int extra; logic [63:0] held;
      decrypt = 1'b0; din = PA; key1 = k56(KX); key2 = k56(KX); key3 = k56(KA);
      start = 1'b1;
      lat = -1;
      for (int k = 1; k <= 60; k++) begin
         @(negedge clk);
         if (k == 1) start = 1'b0;
         if (k == 10) begin
            start = 1'b1; decrypt = 1'b1; din = PB;
            key1 = k56(KB); key2 = k56(KC); key3 = k56(KY);
         end
         if (k == 11) start = 1'b0;
         if (done && lat < 0) begin
            lat = k;
            held = dout;
         end
      end
      check_int("R9 latency unchanged", lat, 48);
      check64("R9 result unchanged", held, CA);
      extra = 0;
      for (int k = 0; k < 70; k++) begin
         @(negedge clk);
         if (done) extra++;
      end
      check_int("R9 no extra operation", extra, 0);
      check64("R8 dout held", dout, CA);
   endtask

   task automatic t_back_to_back;
      int lat; logic [63:0] r1, r2;
      decrypt = 1'b0; din = PA; key1 = k56(KA); key2 = k56(KA); key3 = k56(KA);
      start = 1'b1;
      for (int k = 1; k <= 60; k++) begin
         @(negedge clk);
         if (k == 1) start = 1'b0;
         if (done) break;
      end
      r1 = dout;
      decrypt = 1'b0; din = PB; key1 = k56(KB); key2 = k56(KB); key3 = k56(KB);
      start = 1'b1;
      lat = -1;
      for (int k = 1; k <= 60; k++) begin
         @(negedge clk);
         if (k == 1) start = 1'b0;
         if (k == 47) check64("R8 dout before second done", dout, r1);
         if (done) begin
            lat = k;
            break;
         end
      end
      r2 = dout;
      check64("R10 first result", r1, CA);
      check_int("R10 second latency", lat, 48);
      check64("R10 second result", r2, CB);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single_des();
      t_enc_order();
      t_dec_order();
      t_round_trip();
      t_ignore_start();
      t_back_to_back();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule